// File: doc/BRIEF.md
# Prioritized Interrupt Arbiter with Single-Source Promotion

This unit sits beside a CPU core and decides which interrupt the core should take next. Maskable sources come from two places. One is a set of peripheral lines, each with its own flag and local enable. The other is an external active-low IRQ pin, which can be set to respond to a level or to a falling edge. A separate active-low non-maskable input, XIRQ, ranks above all of them. The unit keeps the global I and X mask bits. It applies them to the requests, picks one winner and hands the CPU the low byte of that winner's vector address.

The fixed default order can be changed by a promotion register. It holds bits [7:1] of a vector low byte, and the matching maskable source moves to the top of the maskable order. The unit also models how I and X change when an interrupt is taken, when the CPU returns from an interrupt and when the unit is reset. A small save stack lets nested interrupts return correctly.

The request to the CPU is a valid/ready stream. `req_valid` rises when there is a winner and no request is already open. `req_vec` and `req_xirq` then stay frozen for as long as `req_ready` is low, so the CPU may stall the request for any number of cycles. The cycle in which both `req_valid` and `req_ready` are high is the acknowledge. The mask-write, promotion-write and return inputs are plain one-cycle strobes.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, X=1 and I=1, no request is pending, and the promoted slot selects the IRQ pin (vector byte 0xF2).
- R2: Peripheral source j (0 to NSRC-1) has vector low byte 0xF0-2*j. It competes only while its flag and its enable are both 1 and I=0.
- R3: With no promotion in effect, the IRQ pin wins over every peripheral source. Among peripheral sources, the lower index wins.
- R4: A promotion-register write compares data bits [7:1] with bits [7:1] of each maskable vector byte. The matching source outranks all other maskable sources. A value that matches no vector leaves the default order in force.
- R5: A promotion write made while I=0 is ignored.
- R6: When `irq_edge_mode`=0, the IRQ pin (vector 0xF2) is pending while it is low. When `irq_edge_mode`=1, a falling edge is latched. The latch stays pending after the pin returns high and clears only when the CPU acknowledges the IRQ.
- R7: XIRQ (low-active, vector 0xF4, `req_xirq`=1) is not gated by I and beats every maskable source. It is blocked while X=1.
- R8: A software mask write loads I directly. It can clear X but can never set X.
- R9: Acknowledging an XIRQ sets both X and I. Acknowledging a maskable interrupt sets I and leaves X unchanged.
- R10: A return pulse restores X and I to their values before the most recently acknowledged, still-open interrupt. Nesting is supported up to STACK_DEPTH levels.
- R11: `req_valid` rises on the clock edge after a winner appears while no request is open. `req_vec` and `req_xirq` stay stable until `req_ready` is sampled high, and that edge retires the request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_n | input | 1 | External maskable interrupt pin, active low |
| irq_edge_mode | input | 1 | 0: IRQ level sensitive, 1: IRQ falling-edge sensitive |
| xirq_n | input | 1 | Non-maskable interrupt input, active low |
| src_flag | input | NSRC | Peripheral event flags |
| src_en | input | NSRC | Peripheral local enables |
| sw_mask_wr | input | 1 | Software write strobe for I and X |
| sw_mask_i | input | 1 | New I value |
| sw_mask_x | input | 1 | New X value (can only clear X) |
| prio_wr | input | 1 | Promotion register write strobe |
| prio_data | input | 8 | Vector low byte of the source to promote |
| rti | input | 1 | Return-from-interrupt pulse |
| req_valid | output | 1 | Interrupt request to the CPU |
| req_ready | input | 1 | CPU takes the request |
| req_vec | output | 8 | Vector low byte of the requested source |
| req_xirq | output | 1 | Request is the non-maskable input |
| i_mask | output | 1 | Current I bit |
| x_mask | output | 1 | Current X bit |

## Verification
The hardest state to reach from the ports is a nested pair of interrupts that must then unwind in order. It needs a maskable interrupt taken with both masks clear, then an XIRQ taken inside that handler, then two returns. Each return must reproduce a different saved pair of X and I. The bench clears both masks, has a peripheral request acknowledged, pulls XIRQ low during that handler and acknowledges it, and then issues two return pulses. After each return it checks X and I, and at the end it checks that the still-set flag requests again. A short edge-mode pulse that is gone before the CPU acknowledges is the second hard case. It is driven for a single cycle and the request is checked after the pin has already gone high.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  localparam logic [7:0] VEC_XIRQ = 8'hF4;
  localparam logic [7:0] VEC_IRQ  = 8'hF2;

  // Maskable slot k: 0 is the IRQ pin, k>=1 is peripheral k-1
  function automatic logic [7:0] vec_of(input int k);
    return VEC_IRQ - 8'(2 * k);
  endfunction
endpackage

// File: rtl/irq_pin_det.sv
module irq_pin_det (
  input  logic clk,
  input  logic rst_n,
  input  logic irq_n,
  input  logic edge_mode,
  input  logic clr,
  output logic pend
);
  logic irq_n_q;
  logic latch_q;
  logic fall;

  assign fall = irq_n_q && !irq_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_n_q <= 1'b1;
      latch_q <= 1'b0;
    end else begin
      irq_n_q <= irq_n;
      if (edge_mode && fall)
        latch_q <= 1'b1;
      else if (clr)
        latch_q <= 1'b0;
    end
  end

  assign pend = edge_mode ? (latch_q || fall) : !irq_n;

  AST_EDGE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    latch_q && !clr |=> latch_q); // R6
endmodule

// File: rtl/irq_prio_arb.sv
module irq_prio_arb #(
  parameter int NM = 9
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NM-1:0]         pend,
  input  logic [6:0]            sel,
  output logic [NM-1:0]         grant,
  output logic                  hit,
  output logic [$clog2(NM)-1:0] idx
);
  import irq_prio_pkg::*;
  localparam int IW = $clog2(NM);

  logic [NM-1:0] promo;
  logic [NM-1:0] hot;
  logic          found;
  logic [7:0]    v;

  always_comb begin
    promo = '0;
    for (int k = 0; k < NM; k++) begin
      v = vec_of(k);
      promo[k] = (v[7:1] == sel);
    end
    hot   = pend & promo;
    hit   = |pend;
    grant = '0;
    found = 1'b0;
    if (|hot) begin
      grant = hot;
    end else begin
      for (int k = 0; k < NM; k++) begin
        if (pend[k] && !found) begin
          grant[k] = 1'b1;
          found    = 1'b1;
        end
      end
    end
    idx = '0;
    for (int k = 0; k < NM; k++)
      if (grant[k]) idx = IW'(k);
  end

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant) && (hit == (grant != '0))); // R3
endmodule

// File: rtl/irq_mask_stack.sv
module irq_mask_stack #(
  parameter int DEPTH = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ack,
  input  logic ack_x,
  input  logic rti,
  input  logic sw_wr,
  input  logic sw_i,
  input  logic sw_x,
  output logic i_mask,
  output logic x_mask
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [1:0]    stk [DEPTH];
  logic [CW-1:0] cnt;
  logic [CW-1:0] cm1;
  logic          full;

  assign full = (cnt == CW'(DEPTH));
  assign cm1  = cnt - CW'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      x_mask <= 1'b1;
      i_mask <= 1'b1;
      cnt    <= '0;
    end else if (ack) begin
      if (!full) begin
        stk[cnt[AW-1:0]] <= {x_mask, i_mask};
        cnt <= cnt + CW'(1);
      end
      i_mask <= 1'b1;
      if (ack_x) x_mask <= 1'b1;
    end else if (rti && cnt != '0) begin
      {x_mask, i_mask} <= stk[cm1[AW-1:0]];
      cnt <= cm1;
    end else if (sw_wr) begin
      i_mask <= sw_i;
      x_mask <= x_mask & sw_x;
    end
  end

  AST_X_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
    !x_mask && !ack && !rti |=> !x_mask); // R8
  AST_STACK_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> !full); // R10
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
  parameter int NSRC        = 8,
  parameter int STACK_DEPTH = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            irq_n,
  input  logic            irq_edge_mode,
  input  logic            xirq_n,
  input  logic [NSRC-1:0] src_flag,
  input  logic [NSRC-1:0] src_en,
  input  logic            sw_mask_wr,
  input  logic            sw_mask_i,
  input  logic            sw_mask_x,
  input  logic            prio_wr,
  input  logic [7:0]      prio_data,
  input  logic            rti,
  output logic            req_valid,
  input  logic            req_ready,
  output logic [7:0]      req_vec,
  output logic            req_xirq,
  output logic            i_mask,
  output logic            x_mask
);
  import irq_prio_pkg::*;
  localparam int NM = NSRC + 1;
  localparam int IW = $clog2(NM);

  logic [6:0]    prio_q;
  logic          irq_pend;
  logic [NM-1:0] pend;
  logic [NM-1:0] grant;
  logic          arb_hit;
  logic [IW-1:0] idx;
  logic          xirq_win;
  logic          mask_win;
  logic          src0_q;
  logic          ack;

  assign ack = req_valid && req_ready;

  irq_pin_det i_pin (
    .clk(clk), .rst_n(rst_n), .irq_n(irq_n), .edge_mode(irq_edge_mode),
    .clr(ack && src0_q), .pend(irq_pend)
  );

  assign pend = {src_flag & src_en, irq_pend};

  irq_prio_arb #(.NM(NM)) i_arb (
    .clk(clk), .rst_n(rst_n), .pend(pend), .sel(prio_q),
    .grant(grant), .hit(arb_hit), .idx(idx)
  );

  irq_mask_stack #(.DEPTH(STACK_DEPTH)) i_mask_stk (
    .clk(clk), .rst_n(rst_n), .ack(ack), .ack_x(ack && req_xirq),
    .rti(rti), .sw_wr(sw_mask_wr), .sw_i(sw_mask_i), .sw_x(sw_mask_x),
    .i_mask(i_mask), .x_mask(x_mask)
  );

  assign xirq_win = !x_mask && !xirq_n;
  assign mask_win = !i_mask && arb_hit;

  always_ff @(posedge clk) begin
    if (!rst_n)
      prio_q <= VEC_IRQ[7:1];
    else if (prio_wr && i_mask)
      prio_q <= prio_data[7:1];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_valid <= 1'b0;
      req_vec   <= '0;
      req_xirq  <= 1'b0;
      src0_q    <= 1'b0;
    end else if (req_valid) begin
      if (req_ready) req_valid <= 1'b0;
    end else if (xirq_win || mask_win) begin
      req_valid <= 1'b1;
      req_vec   <= xirq_win ? VEC_XIRQ : vec_of(int'(idx));
      req_xirq  <= xirq_win;
      src0_q    <= !xirq_win && grant[0];
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_vec) && $stable(req_xirq)); // R11
  AST_PRIO_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    prio_wr && !i_mask |=> $stable(prio_q)); // R5
  AST_ACK_SETS_I: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> i_mask); // R9
  AST_XIRQ_SETS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    ack && req_xirq |=> i_mask && x_mask); // R9
endmodule

// File: tb/test_irq_prio_ctrl.sv
module test_irq_prio_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       irq_n = 1'b1, irq_edge_mode = 1'b0, xirq_n = 1'b1;
  logic [7:0] src_flag = '0, src_en = '0;
  logic       sw_mask_wr = 0, sw_mask_i = 0, sw_mask_x = 0;
  logic       prio_wr = 0;
  logic [7:0] prio_data = '0;
  logic       rti = 0, req_ready = 0;
  logic       req_valid, req_xirq, i_mask, x_mask;
  logic [7:0] req_vec;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  irq_prio_ctrl i_irq_prio_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_n(irq_n), .irq_edge_mode(irq_edge_mode),
    .xirq_n(xirq_n), .src_flag(src_flag), .src_en(src_en),
    .sw_mask_wr(sw_mask_wr), .sw_mask_i(sw_mask_i), .sw_mask_x(sw_mask_x),
    .prio_wr(prio_wr), .prio_data(prio_data), .rti(rti),
    .req_valid(req_valid), .req_ready(req_ready), .req_vec(req_vec),
    .req_xirq(req_xirq), .i_mask(i_mask), .x_mask(x_mask)
  );

  // {flags, enables, irq_n, xirq_n, clear_x, promo byte, exp_valid, exp_vec}
  localparam logic [35:0] TBL [10] = '{
    {8'h01, 8'h01, 1'b1, 1'b1, 1'b1, 8'hF2, 1'b1, 8'hF0}, // R2 single source
    {8'h01, 8'h00, 1'b1, 1'b1, 1'b1, 8'hF2, 1'b0, 8'h00}, // R2 enable off
    {8'h0C, 8'h0C, 1'b1, 1'b1, 1'b1, 8'hF2, 1'b1, 8'hEC}, // R3 lower index
    {8'h0C, 8'hFF, 1'b0, 1'b1, 1'b1, 8'hF2, 1'b1, 8'hF2}, // R3 R6 IRQ level
    {8'h81, 8'h81, 1'b1, 1'b1, 1'b1, 8'hE2, 1'b1, 8'hE2}, // R4 promoted
    {8'h81, 8'h81, 1'b0, 1'b1, 1'b1, 8'hE2, 1'b1, 8'hE2}, // R4 beats IRQ
    {8'h81, 8'h81, 1'b1, 1'b1, 1'b1, 8'h00, 1'b1, 8'hF0}, // R4 no match
    {8'h81, 8'h81, 1'b1, 1'b0, 1'b1, 8'hF2, 1'b1, 8'hF4}, // R7 XIRQ wins
    {8'h00, 8'h00, 1'b1, 1'b0, 1'b0, 8'hF2, 1'b0, 8'h00}, // R7 X set blocks
    {8'h81, 8'h81, 1'b1, 1'b1, 1'b1, 8'hE3, 1'b1, 8'hE2}  // R4 bit0 ignored
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 0; irq_n = 1; xirq_n = 1; irq_edge_mode = 0;
    src_flag = '0; src_en = '0; req_ready = 0;
    repeat (2) @(posedge clk);
    @(negedge clk); rst_n = 1;
  endtask

  task automatic do_mask(input logic iv, input logic xv);
    sw_mask_wr = 1; sw_mask_i = iv; sw_mask_x = xv;
    @(posedge clk); @(negedge clk); sw_mask_wr = 0;
  endtask

  task automatic do_prio(input logic [7:0] v);
    prio_wr = 1; prio_data = v;
    @(posedge clk); @(negedge clk); prio_wr = 0;
  endtask

  task automatic do_ack();
    req_ready = 1;
    @(posedge clk); @(negedge clk); req_ready = 0;
  endtask

  task automatic do_rti();
    rti = 1;
    @(posedge clk); @(negedge clk); rti = 0;
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1 reset state
    do_reset();
    check("R1 x", 32'(x_mask), 1);
    check("R1 i", 32'(i_mask), 1);
    check("R1 valid", 32'(req_valid), 0);

    for (int n = 0; n < 10; n++) begin
      do_reset();
      do_prio(TBL[n][16:9]);
      src_flag = TBL[n][35:28]; src_en = TBL[n][27:20];
      irq_n = TBL[n][19]; xirq_n = TBL[n][18];
      do_mask(1'b0, !TBL[n][17]);
      step();
      check($sformatf("table %0d valid", n), 32'(req_valid), 32'(TBL[n][8]));
      if (TBL[n][8]) check($sformatf("table %0d vec", n), 32'(req_vec), 32'(TBL[n][7:0]));
      if (n == 7) check("R7 xirq flag", 32'(req_xirq), 1);
    end

    // R1 default promotion is IRQ; R2 I set blocks maskable
    do_reset();
    src_flag = 8'h01; src_en = 8'h01; irq_n = 0;
    step();
    check("R2 I blocks", 32'(req_valid), 0);
    do_mask(1'b0, 1'b1); step();
    check("R1 default IRQ top", 32'(req_vec), 32'h F2);

    // R5 promotion ignored while I clear
    do_reset();
    do_mask(1'b0, 1'b1);
    do_prio(8'hE2);
    src_flag = 8'h81; src_en = 8'h81;
    step();
    check("R5 write ignored", 32'(req_vec), 32'hF0);

    // R8 X clear only
    do_reset();
    do_mask(1'b1, 1'b0);
    check("R8 x cleared", 32'(x_mask), 0);
    do_mask(1'b0, 1'b1);
    check("R8 x stays clear", 32'(x_mask), 0);
    check("R8 i written", 32'(i_mask), 0);

    // R6 edge mode short pulse
    do_reset();
    irq_edge_mode = 1;
    do_mask(1'b0, 1'b1);
    irq_n = 0; @(posedge clk); @(negedge clk); irq_n = 1;
    check("R6 edge latched valid", 32'(req_valid), 1);
    check("R6 edge vec", 32'(req_vec), 32'hF2);
    do_ack();
    check("R9 maskable ack sets I", 32'(i_mask), 1);
    check("R9 maskable ack keeps X", 32'(x_mask), 1);
    do_mask(1'b0, 1'b1); step();
    check("R6 latch cleared by ack", 32'(req_valid), 0);

    // R9 R10 nesting
    do_reset();
    src_flag = 8'h01; src_en = 8'h01;
    do_mask(1'b0, 1'b0); step();
    check("R2 nested first vec", 32'(req_vec), 32'hF0);
    do_ack();
    check("R9 I after maskable", 32'(i_mask), 1);
    check("R9 X after maskable", 32'(x_mask), 0);
    xirq_n = 0; step();
    check("R7 XIRQ with I set", 32'(req_vec), 32'hF4);
    do_ack();
    check("R9 XIRQ sets X", 32'(x_mask), 1);
    check("R9 XIRQ sets I", 32'(i_mask), 1);
    xirq_n = 1;
    do_rti();
    check("R10 inner X", 32'(x_mask), 0);
    check("R10 inner I", 32'(i_mask), 1);
    do_rti();
    check("R10 outer I", 32'(i_mask), 0);
    check("R10 outer X", 32'(x_mask), 0);
    step();
    check("R10 request again", 32'(req_valid), 1);

    // R11 hold under back-pressure
    do_reset();
    src_flag = 8'h02; src_en = 8'h02;
    do_mask(1'b0, 1'b1); step();
    check("R11 first vec", 32'(req_vec), 32'hEE);
    irq_n = 0;
    repeat (3) step();
    check("R11 held valid", 32'(req_valid), 1);
    check("R11 held vec", 32'(req_vec), 32'hEE);
    do_ack();
    check("R11 retired", 32'(req_valid), 0);
    irq_n = 1;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule